// File: doc/BRIEF.md
# Flash Status and Write-Protect Unit

This block owns the status byte of a serial flash device and rules on every command that could change the array or the status byte. A command sequencer sends it one-cycle strobes: write enable, write disable, status write with a data byte, page program with an address, sector erase with an address, and bulk erase. The unit checks the write-enable latch, the block-protect field, the protect pin and the status-register lock bit. It answers each strobe with a one-cycle accept or reject pulse. An accepted program, erase or status write starts a self-timed busy cycle, and its length is a parameter in system clocks.

A control state machine has three states. INHIBIT is entered at reset and on the power-up input. READY evaluates commands. BUSY covers a self-timed cycle. The transitions are: INHIBIT to READY when the inhibit timer expires; READY to BUSY when a status write, program or erase is accepted; BUSY to READY when the cycle timer expires; and any state to INHIBIT on the power-up input. One down-counter times both the inhibit window and the busy cycles. A decoder turns the block-protect field into the lowest protected sector and a per-sector protection map.

Top module: `flash_wp_unit`

## Requirements
- R1: After reset or a power-up pulse the status byte reads 00h. Its layout is bit 7 lock (SRWD), bits 6 and 5 always 0, bits 4..2 block-protect BP[2:0], bit 1 write-enable latch WEL, bit 0 write-in-progress WIP.
- R2: A write-enable strobe sets WEL. A write-disable strobe clears it. Both are accepted in READY.
- R3: A status write, page program, sector erase or bulk erase is rejected when WEL is 0.
- R4: A status write is rejected while SRWD is 1 and the protect pin `wp_n_i` is low, whichever of the two became true first. Raising the pin lets the next status write through.
- R5: An accepted status write changes only SRWD (data bit 7) and BP (data bits 4..2). Data bits 6, 5, 1 and 0 have no effect.
- R6: `prot_en_o` is 0 for BP=000. Otherwise `prot_lo_o` names the lowest protected sector: 001 gives 15, 010 gives 14, 011 gives 12, 100 gives 8, and 101, 110 and 111 give 0. The protected range always ends at the top sector.
- R7: A page program is rejected when its sector, taken from address bits [19:16], lies in the protected range.
- R8: A sector erase or bulk erase is accepted only when BP is 000.
- R9: An accepted command holds `busy_o` and status bit 0 at 1 for exactly its parameterised number of cycles: WRSR_CYC for a status write, PP_CYC for a program, SE_CYC for a sector erase, BE_CYC for a bulk erase. The status byte stays readable during the cycle.
- R10: WEL clears in the same cycle that WIP falls. A status write's new SRWD and BP values appear at that same cycle.
- R11: Any command strobe that arrives during a busy cycle is rejected and leaves the status byte unchanged.
- R12: For PUW_CYC cycles after reset or a power-up pulse, write enable, status write, program and both erases are rejected. The power-up pulse also aborts any busy cycle.
- R13: Every strobe produces exactly one of `accept_o` or `reject_o` for one cycle, in the cycle after the strobe. A rejected command leaves the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_up_i | input | 1 | Power-up indication; clears the status byte and restarts the inhibit window |
| wp_n_i | input | 1 | Write-protect pin, active low |
| cmd_wren_i | input | 1 | Write-enable strobe |
| cmd_wrdi_i | input | 1 | Write-disable strobe |
| cmd_wrsr_i | input | 1 | Status-write strobe |
| cmd_pp_i | input | 1 | Page-program strobe |
| cmd_se_i | input | 1 | Sector-erase strobe |
| cmd_be_i | input | 1 | Bulk-erase strobe |
| wrsr_data_i | input | 8 | Data byte for a status write |
| cmd_addr_i | input | ADDR_W | Byte address for program or sector erase |
| status_o | output | 8 | Status byte |
| accept_o | output | 1 | One-cycle accept pulse |
| reject_o | output | 1 | One-cycle reject pulse |
| busy_o | output | 1 | Self-timed cycle in progress |
| prot_en_o | output | 1 | Some sectors are protected |
| prot_lo_o | output | SECT_BITS | Lowest protected sector |

## Verification
The hardest state to reach is hardware protection entered in the less common order: the lock bit is written while the pin is already low, so the very write that locks the register is accepted and the next one is refused. The stimulus reaches it with a write enable, then a status write of 80h with the pin low, then a second enabled write with the pin still low. The pin is then raised and the write is repeated. A second hard case is a strobe that lands inside a busy cycle. The bench issues a write enable on the cycle right after an accepted program, then reads the status byte mid-cycle to confirm that both WIP and WEL are still set.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

    typedef enum logic [1:0] {
        ST_INHIBIT = 2'd0,
        ST_READY   = 2'd1,
        ST_BUSY    = 2'd2
    } fsw_state_e;

    localparam int STAT_WIP  = 0;
    localparam int STAT_WEL  = 1;
    localparam int STAT_BP_LO = 2;
    localparam int STAT_SRWD = 7;

    function automatic int fsw_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsw_cycle_timer.sv
module fsw_cycle_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/fsw_prot_decode.sv
module fsw_prot_decode #(
    parameter int SECT_BITS = 4
) (
    input  logic [2:0]           bp_i,
    input  logic [SECT_BITS-1:0] sector_i,
    output logic                 en_o,
    output logic [SECT_BITS-1:0] lo_o,
    output logic                 hit_o
);

    localparam int NUM_SECT = 1 << SECT_BITS;

    logic [NUM_SECT-1:0] map;

    always_comb begin
        en_o = (bp_i != 3'd0);
        lo_o = '0;
        if (bp_i != 3'd0 && (int'(bp_i) - 1) < SECT_BITS) begin
            lo_o = SECT_BITS'(NUM_SECT - (1 << (int'(bp_i) - 1)));
        end
    end

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_map
        assign map[s] = en_o && (s >= int'(lo_o));
    end

    assign hit_o = map[sector_i];

endmodule

// File: rtl/flash_wp_unit.sv
module flash_wp_unit
    import fsw_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int SECT_BITS = 4,
    parameter int PUW_CYC   = 8,
    parameter int WRSR_CYC  = 4,
    parameter int PP_CYC    = 6,
    parameter int SE_CYC    = 10,
    parameter int BE_CYC    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_up_i,
    input  logic                 wp_n_i,
    input  logic                 cmd_wren_i,
    input  logic                 cmd_wrdi_i,
    input  logic                 cmd_wrsr_i,
    input  logic                 cmd_pp_i,
    input  logic                 cmd_se_i,
    input  logic                 cmd_be_i,
    input  logic [7:0]           wrsr_data_i,
    input  logic [ADDR_W-1:0]    cmd_addr_i,
    output logic [7:0]           status_o,
    output logic                 accept_o,
    output logic                 reject_o,
    output logic                 busy_o,
    output logic                 prot_en_o,
    output logic [SECT_BITS-1:0] prot_lo_o
);

    localparam int MAX_CYC = fsw_max(fsw_max(PUW_CYC, WRSR_CYC),
                                     fsw_max(fsw_max(PP_CYC, SE_CYC), BE_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    fsw_state_e       state_q, state_d;
    logic             wel_q, wel_d;
    logic             srwd_q, srwd_d;
    logic [2:0]       bp_q, bp_d;
    logic             pend_wr_q, pend_wr_d;
    logic             pend_srwd_q, pend_srwd_d;
    logic [2:0]       pend_bp_q, pend_bp_d;
    logic             acc_q, acc_d;
    logic             rej_q, rej_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             pp_hit;
    logic             any_cmd;
    logic             hw_locked;
    logic             unused_bits;

    assign unused_bits = ^{cmd_addr_i[ADDR_W-SECT_BITS-1:0], wrsr_data_i[6:5], wrsr_data_i[1:0]};

    fsw_cycle_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (PUW_CYC - 1)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    fsw_prot_decode #(
        .SECT_BITS (SECT_BITS)
    ) u_decode (
        .bp_i     (bp_q),
        .sector_i (cmd_addr_i[ADDR_W-1 -: SECT_BITS]),
        .en_o     (prot_en_o),
        .lo_o     (prot_lo_o),
        .hit_o    (pp_hit)
    );

    assign any_cmd   = cmd_wren_i | cmd_wrdi_i | cmd_wrsr_i | cmd_pp_i | cmd_se_i | cmd_be_i;
    assign hw_locked = srwd_q & ~wp_n_i;

    // state register and status storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_INHIBIT;
            wel_q       <= 1'b0;
            srwd_q      <= 1'b0;
            bp_q        <= 3'd0;
            pend_wr_q   <= 1'b0;
            pend_srwd_q <= 1'b0;
            pend_bp_q   <= 3'd0;
            acc_q       <= 1'b0;
            rej_q       <= 1'b0;
        end else begin
            state_q     <= state_d;
            wel_q       <= wel_d;
            srwd_q      <= srwd_d;
            bp_q        <= bp_d;
            pend_wr_q   <= pend_wr_d;
            pend_srwd_q <= pend_srwd_d;
            pend_bp_q   <= pend_bp_d;
            acc_q       <= acc_d;
            rej_q       <= rej_d;
        end
    end

    // next-state and command decisions
    always_comb begin
        state_d     = state_q;
        wel_d       = wel_q;
        srwd_d      = srwd_q;
        bp_d        = bp_q;
        pend_wr_d   = pend_wr_q;
        pend_srwd_d = pend_srwd_q;
        pend_bp_d   = pend_bp_q;
        acc_d       = 1'b0;
        rej_d       = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        if (pwr_up_i) begin
            state_d   = ST_INHIBIT;
            tmr_load  = 1'b1;
            tmr_val   = CNT_W'(PUW_CYC - 1);
            wel_d     = 1'b0;
            srwd_d    = 1'b0;
            bp_d      = 3'd0;
            pend_wr_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_INHIBIT: begin
                    if (tmr_done) state_d = ST_READY;
                    if (cmd_wrdi_i) begin
                        acc_d = 1'b1;
                    end else if (any_cmd) begin
                        rej_d = 1'b1;
                    end
                end
                ST_READY: begin
                    if (cmd_wren_i) begin
                        wel_d = 1'b1;
                        acc_d = 1'b1;
                    end else if (cmd_wrdi_i) begin
                        wel_d = 1'b0;
                        acc_d = 1'b1;
                    end else if (cmd_wrsr_i) begin
                        if (wel_q && !hw_locked) begin
                            state_d     = ST_BUSY;
                            tmr_load    = 1'b1;
                            tmr_val     = CNT_W'(WRSR_CYC - 1);
                            pend_wr_d   = 1'b1;
                            pend_srwd_d = wrsr_data_i[7];
                            pend_bp_d   = wrsr_data_i[4:2];
                            acc_d       = 1'b1;
                        end else begin
                            rej_d = 1'b1;
                        end
                    end else if (cmd_pp_i) begin
                        if (wel_q && !pp_hit) begin
                            state_d  = ST_BUSY;
                            tmr_load = 1'b1;
                            tmr_val  = CNT_W'(PP_CYC - 1);
                            acc_d    = 1'b1;
                        end else begin
                            rej_d = 1'b1;
                        end
                    end else if (cmd_se_i) begin
                        if (wel_q && bp_q == 3'd0) begin
                            state_d  = ST_BUSY;
                            tmr_load = 1'b1;
                            tmr_val  = CNT_W'(SE_CYC - 1);
                            acc_d    = 1'b1;
                        end else begin
                            rej_d = 1'b1;
                        end
                    end else if (cmd_be_i) begin
                        if (wel_q && bp_q == 3'd0) begin
                            state_d  = ST_BUSY;
                            tmr_load = 1'b1;
                            tmr_val  = CNT_W'(BE_CYC - 1);
                            acc_d    = 1'b1;
                        end else begin
                            rej_d = 1'b1;
                        end
                    end
                end
                ST_BUSY: begin
                    if (any_cmd) rej_d = 1'b1;
                    if (tmr_done) begin
                        state_d   = ST_READY;
                        wel_d     = 1'b0;
                        pend_wr_d = 1'b0;
                        if (pend_wr_q) begin
                            srwd_d = pend_srwd_q;
                            bp_d   = pend_bp_q;
                        end
                    end
                end
                default: state_d = ST_INHIBIT;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o                = (state_q == ST_BUSY);
        status_o              = 8'h00;
        status_o[STAT_SRWD]   = srwd_q;
        status_o[STAT_BP_LO +: 3] = bp_q;
        status_o[STAT_WEL]    = wel_q;
        status_o[STAT_WIP]    = busy_o;
        accept_o              = acc_q;
        reject_o              = rej_q;
    end

    // R13
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_wren_i, cmd_wrdi_i, cmd_wrsr_i, cmd_pp_i, cmd_se_i, cmd_be_i}));

    // R10
    wel_clear_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !wel_q);

    // R4
    hw_lock_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && cmd_wrsr_i && srwd_q && !wp_n_i && !pwr_up_i)
        |=> reject_o && $stable(srwd_q) && $stable(bp_q));

    // R8
    erase_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && (cmd_se_i || cmd_be_i) && bp_q != 3'd0 && !pwr_up_i)
        |=> !busy_o && reject_o);

    // R12
    inhibit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INHIBIT && (cmd_wren_i || cmd_wrsr_i || cmd_pp_i || cmd_se_i || cmd_be_i))
        |=> !accept_o && !wel_q);

    // R13
    reject_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reject_o && !$fell(busy_o)) |-> $stable(status_o));

    // R13
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept_o && reject_o));

endmodule

// File: tb/test_flash_wp_unit.sv
`timescale 1ns/1ps
module test_flash_wp_unit;

    localparam int ADDR_W = 20;
    localparam int SB     = 4;
    localparam int PUW    = 8;
    localparam int T_WRSR = 4;
    localparam int T_PP   = 6;
    localparam int T_SE   = 10;
    localparam int T_BE   = 12;

    // command codes used only by the bench
    localparam logic [2:0] C_WREN = 3'd1, C_WRDI = 3'd2, C_WRSR = 3'd3,
                           C_PP = 3'd4, C_SE = 3'd5, C_BE = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_up = 1'b0;
    logic wp_n = 1'b1;
    logic wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0, pp = 1'b0, se = 1'b0, be = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] status;
    logic acc, rej, busy, pen;
    logic [SB-1:0] plo;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    flash_wp_unit #(
        .ADDR_W(ADDR_W), .SECT_BITS(SB), .PUW_CYC(PUW), .WRSR_CYC(T_WRSR),
        .PP_CYC(T_PP), .SE_CYC(T_SE), .BE_CYC(T_BE)
    ) i_flash_wp_unit (
        .clk(clk), .rst_n(rst_n), .pwr_up_i(pwr_up), .wp_n_i(wp_n),
        .cmd_wren_i(wren), .cmd_wrdi_i(wrdi), .cmd_wrsr_i(wrsr), .cmd_pp_i(pp),
        .cmd_se_i(se), .cmd_be_i(be), .wrsr_data_i(wdata), .cmd_addr_i(addr),
        .status_o(status), .accept_o(acc), .reject_o(rej), .busy_o(busy),
        .prot_en_o(pen), .prot_lo_o(plo)
    );

    // cmd, data, addr, wp_n, accept, status after, busy cycles
    localparam int NV = 26;
    localparam logic [47:0] VECS [NV] = '{
        {C_PP,   8'h00, 20'h00100, 1'b1, 1'b0, 8'h00, 7'd0},       // R3
        {C_WREN, 8'h00, 20'h00000, 1'b1, 1'b1, 8'h02, 7'd0},       // R2
        {C_WRSR, 8'hFF, 20'h00000, 1'b1, 1'b1, 8'h9C, 7'd4},       // R5
        {C_WREN, 8'h00, 20'h00000, 1'b1, 1'b1, 8'h9E, 7'd0},
        {C_PP,   8'h00, 20'h00100, 1'b1, 1'b0, 8'h9E, 7'd0},       // R7
        {C_SE,   8'h00, 20'h00000, 1'b1, 1'b0, 8'h9E, 7'd0},       // R8
        {C_BE,   8'h00, 20'h00000, 1'b1, 1'b0, 8'h9E, 7'd0},       // R8
        {C_WRSR, 8'h00, 20'h00000, 1'b0, 1'b0, 8'h9E, 7'd0},       // R4
        {C_WRSR, 8'h88, 20'h00000, 1'b1, 1'b1, 8'h88, 7'd4},       // R4
        {C_WREN, 8'h00, 20'h00000, 1'b1, 1'b1, 8'h8A, 7'd0},
        {C_PP,   8'h00, 20'hF0000, 1'b1, 1'b0, 8'h8A, 7'd0},       // R7
        {C_PP,   8'h00, 20'hD0000, 1'b1, 1'b1, 8'h88, 7'd6},       // R9
        {C_WREN, 8'h00, 20'h00000, 1'b1, 1'b1, 8'h8A, 7'd0},
        {C_WRSR, 8'h10, 20'h00000, 1'b1, 1'b1, 8'h10, 7'd4},
        {C_WREN, 8'h00, 20'h00000, 1'b1, 1'b1, 8'h12, 7'd0},
        {C_PP,   8'h00, 20'h80000, 1'b1, 1'b0, 8'h12, 7'd0},       // R7
        {C_PP,   8'h00, 20'h70000, 1'b1, 1'b1, 8'h10, 7'd6},
        {C_WREN, 8'h00, 20'h00000, 1'b1, 1'b1, 8'h12, 7'd0},
        {C_WRSR, 8'h63, 20'h00000, 1'b1, 1'b1, 8'h00, 7'd4},       // R5
        {C_WREN, 8'h00, 20'h00000, 1'b1, 1'b1, 8'h02, 7'd0},
        {C_SE,   8'h00, 20'h40000, 1'b1, 1'b1, 8'h00, 7'd10},      // R9
        {C_WREN, 8'h00, 20'h00000, 1'b1, 1'b1, 8'h02, 7'd0},
        {C_BE,   8'h00, 20'h00000, 1'b1, 1'b1, 8'h00, 7'd12},      // R9
        {C_WREN, 8'h00, 20'h00000, 1'b1, 1'b1, 8'h02, 7'd0},
        {C_WRDI, 8'h00, 20'h00000, 1'b1, 1'b1, 8'h00, 7'd0},       // R2
        {C_BE,   8'h00, 20'h00000, 1'b1, 1'b0, 8'h00, 7'd0}        // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive one strobe for one cycle; returns at the negedge after the capturing edge
    task automatic issue(input logic [2:0] c, input logic [7:0] d,
                         input logic [ADDR_W-1:0] a, input logic w);
        wdata = d; addr = a; wp_n = w;
        wren = (c == C_WREN); wrdi = (c == C_WRDI); wrsr = (c == C_WRSR);
        pp = (c == C_PP); se = (c == C_SE); be = (c == C_BE);
        @(posedge clk);
        @(negedge clk);
        wren = 1'b0; wrdi = 1'b0; wrsr = 1'b0; pp = 1'b0; se = 1'b0; be = 1'b0;
    endtask

    task automatic run_cmd(input string req, input logic [2:0] c, input logic [7:0] d,
                           input logic [ADDR_W-1:0] a, input logic w, input logic ea,
                           input logic [7:0] es, input int cyc);
        int n;
        issue(c, d, a, w);
        chk({req, " R13 accept"}, 32'(acc), 32'(ea));
        chk({req, " R13 reject"}, 32'(rej), 32'(!ea));
        n = 0;
        while (busy && n < 1000) begin
            n++;
            if (n == 1) chk({req, " R9 WIP mid-cycle"}, 32'(status[0]), 32'd1);
            @(negedge clk);
        end
        chk({req, " R9 busy length"}, 32'(n), 32'(cyc));
        chk({req, " R10 status"}, 32'(status), 32'(es));
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset status", 32'(status), 32'h00);
        chk("R1 reset busy", 32'(busy), 32'd0);
        // R12 write enable rejected in the inhibit window
        run_cmd("R12 inhibit", C_WREN, 8'h00, '0, 1'b1, 1'b0, 8'h00, 0);
        repeat (PUW + 2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [47:0] v;
            v = VECS[i];
            run_cmd($sformatf("vec%0d", i), v[47:45], v[44:37], v[36:17], v[16],
                    v[15], v[14:7], int'(v[6:0]));
        end

        // R6 decode of BP=010
        run_cmd("R6 setup", C_WREN, 8'h00, '0, 1'b1, 1'b1, 8'h02, 0);
        run_cmd("R6 setup", C_WRSR, 8'h08, '0, 1'b1, 1'b1, 8'h08, T_WRSR);
        chk("R6 en bp010", 32'(pen), 32'd1);
        chk("R6 lo bp010", 32'(plo), 32'd14);

        // R11 strobe during a busy cycle
        run_cmd("R11 setup", C_WREN, 8'h00, '0, 1'b1, 1'b1, 8'h0A, 0);
        issue(C_PP, 8'h00, 20'h00000, 1'b1);
        chk("R11 pp accepted", 32'(acc), 32'd1);
        issue(C_WREN, 8'h00, '0, 1'b1);
        chk("R11 busy reject", 32'(rej), 32'd1);
        chk("R11 status held", 32'(status), 32'h0B);
        while (busy) @(negedge clk);
        chk("R10 after pp", 32'(status), 32'h08);

        // R4 lock set while pin already low, then released by the pin
        run_cmd("R4 a", C_WREN, 8'h00, '0, 1'b0, 1'b1, 8'h0A, 0);
        run_cmd("R4 b", C_WRSR, 8'h80, '0, 1'b0, 1'b1, 8'h80, T_WRSR);
        run_cmd("R4 c", C_WREN, 8'h00, '0, 1'b0, 1'b1, 8'h82, 0);
        run_cmd("R4 locked", C_WRSR, 8'h1C, '0, 1'b0, 1'b0, 8'h82, 0);
        run_cmd("R4 pin high", C_WRSR, 8'h1C, '0, 1'b1, 1'b1, 8'h1C, T_WRSR);
        chk("R6 en bp111", 32'(pen), 32'd1);
        chk("R6 lo bp111", 32'(plo), 32'd0);

        // R12 power-up pulse clears status and reopens the inhibit window
        run_cmd("R12 setup", C_WREN, 8'h00, '0, 1'b1, 1'b1, 8'h1E, 0);
        pwr_up = 1'b1;
        @(negedge clk);
        pwr_up = 1'b0;
        chk("R1 status after pwr_up", 32'(status), 32'h00);
        chk("R6 en bp000", 32'(pen), 32'd0);
        run_cmd("R12 reinhibit", C_WREN, 8'h00, '0, 1'b1, 1'b0, 8'h00, 0);
        repeat (PUW + 2) @(negedge clk);
        run_cmd("R12 open", C_WREN, 8'h00, '0, 1'b1, 1'b1, 8'h02, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule